// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Controller

This block sits between a processor's active-low memory chip-enable and the memory it selects. In normal running the select passes straight through. While the system reset state is active, the select is forced inactive (high), so that a supply drop cannot corrupt the memory contents. A `pass_en` flag shows whether the pass path is open, in the way a series transmission gate would be.

If reset arrives while the processor holds the select low, an access is in progress. That access may finish: the pass path stays open for a bounded number of cycles, or until the select returns high, whichever comes first. After reset is released, and also after the block's own power-on reset, the pass path stays closed for a hold period before it opens again. The hold period is either the full release period or half of it, chosen by a parameter. All pins are plain control levels, with no valid/ready handshake: the select is a level, not a stream, and it can neither be stalled nor back-pressured.

Top module: `ce_guard`

## Requirements
- R1: When no reset is active and the hold period has ended, `pass_en` is 1 and `ce_n_out` equals `ce_n_in` in the same cycle.
- R2: Whenever `pass_en` is 0, `ce_n_out` is 1 whatever `ce_n_in` does.
- R3: If `sys_rst` is 1 while `ce_n_in` is 1 and the path is open, `pass_en` drops to 0 in that same cycle, without waiting for a clock edge.
- R4: If `sys_rst` is first sampled at 1 by a clock edge while `ce_n_in` is 0, the path stays open for `DELAY_CYC` more cycles, as long as the select stays low. It closes at the `DELAY_CYC`-th edge after the first sampling edge.
- R5: If `ce_n_in` goes high during that delay window, the path closes at once. It stays closed while `sys_rst` remains 1, even if the select goes low again.
- R6: After the first clock edge that samples `sys_rst` at 0, the path stays closed and opens at the hold-length-th edge after that one. If `sys_rst` returns to 1 during the hold, the path closes again and a full new hold follows the next release.
- R7: While `rst_n` is 0, `pass_en` is 0 and `ce_n_out` is 1. After `rst_n` is released with `sys_rst` at 0, a full hold period passes before the path first opens.
- R8: The hold length is `REL_CYC` when `HALF_HOLD` is 0 and `REL_CYC/2` when `HALF_HOLD` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the block |
| sys_rst | input | 1 | System reset state, 1 = reset active |
| ce_n_in | input | 1 | Processor chip-enable, active low |
| ce_n_out | output | 1 | Gated chip-enable to the memory, active low |
| pass_en | output | 1 | 1 while the pass path is open |

## Verification
The select is toggled freely in normal running, to show that the output follows the input. Reset is then applied with the select high, which must close the path at once, and with the select held low, which must keep the path open for exactly the delay window. A third case lifts the select partway through the window, which separates a timer-driven close from an early, select-driven close. Releasing reset with the select toggling measures the exact hold length on two instances, one full and one half. A reset pulse that lands inside the hold checks that the hold timer restarts rather than resuming.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;
  typedef enum logic [1:0] {
    GS_OPEN  = 2'd0,  // path open, no reset in progress
    GS_DRAIN = 2'd1,  // reset seen mid-access, path open for a bounded time
    GS_SHUT  = 2'd2,  // reset active, path closed
    GS_HOLD  = 2'd3   // reset released, path closed until hold ends
  } gate_st_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/ce_guard_timer.sv
module ce_guard_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ce_guard_fsm.sv
module ce_guard_fsm
  import ce_guard_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 6,
  parameter int unsigned HOLD_CYC  = 20,
  parameter int unsigned CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_rst,
  input  logic          ce_n_in,
  input  logic [CW-1:0] cnt,
  output logic          clr_tmr,
  output logic          pass_en
);
  localparam logic [CW-1:0] DLY_LAST  = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  gate_st_e st, nxt;
  logic     dly_end, hold_end;

  assign dly_end  = (cnt == DLY_LAST);
  assign hold_end = (cnt == HOLD_LAST);

  always_comb begin
    nxt = st;
    unique case (st)
      GS_OPEN:  if (sys_rst)                 nxt = ce_n_in ? GS_SHUT : GS_DRAIN;
      GS_DRAIN: if (ce_n_in || dly_end)      nxt = GS_SHUT;
      GS_SHUT:  if (!sys_rst)                nxt = GS_HOLD;
      GS_HOLD:  if (sys_rst)                 nxt = GS_SHUT;
                else if (hold_end)           nxt = GS_OPEN;
      default:                               nxt = GS_SHUT;
    endcase
  end

  // entering a timed state restarts the shared timer
  assign clr_tmr = (nxt != st);

  always_comb begin
    unique case (st)
      GS_OPEN:  pass_en = !(sys_rst && ce_n_in);
      GS_DRAIN: pass_en = !ce_n_in;
      default:  pass_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= GS_SHUT;
    else        st <= nxt;
  end
endmodule

// File: rtl/ce_guard_gate.sv
module ce_guard_gate (
  input  logic pass_en,
  input  logic ce_n_in,
  output logic ce_n_out
);
  // closed path parks the select at its inactive level
  assign ce_n_out = pass_en ? ce_n_in : 1'b1;
endmodule

// File: rtl/ce_guard.sv
module ce_guard #(
  parameter int unsigned DELAY_CYC = 6,
  parameter int unsigned REL_CYC   = 20,
  parameter bit          HALF_HOLD = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic ce_n_in,
  output logic ce_n_out,
  output logic pass_en
);
  localparam int unsigned HOLD_CYC = HALF_HOLD ? (REL_CYC / 2) : REL_CYC;
  localparam int unsigned MAX_CYC  = (HOLD_CYC > DELAY_CYC) ? HOLD_CYC : DELAY_CYC;
  localparam int unsigned CW       = ce_guard_pkg::cnt_width(MAX_CYC);

  logic [CW-1:0] cnt;
  logic          clr_tmr;
  logic          pass_w;

  ce_guard_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_tmr),
    .cnt   (cnt)
  );

  ce_guard_fsm #(
    .DELAY_CYC (DELAY_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_rst (sys_rst),
    .ce_n_in (ce_n_in),
    .cnt     (cnt),
    .clr_tmr (clr_tmr),
    .pass_en (pass_w)
  );

  ce_guard_gate u_gate (
    .pass_en  (pass_w),
    .ce_n_in  (ce_n_in),
    .ce_n_out (ce_n_out)
  );

  assign pass_en = pass_w;
endmodule

// File: rtl/ce_guard_chk.sv
module ce_guard_chk #(
  parameter int unsigned DELAY_CYC = 6,
  parameter int unsigned HOLD_CYC  = 20
) (
  input logic clk,
  input logic rst_n,
  input logic sys_rst,
  input logic ce_n_in,
  input logic ce_n_out,
  input logic pass_en
);
  logic [15:0] drain_run, hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_run <= '0;
      hold_run  <= '0;
    end else begin
      drain_run <= (sys_rst && pass_en)   ? ((drain_run != '1) ? drain_run + 1'b1 : drain_run) : '0;
      hold_run  <= (!sys_rst && !pass_en) ? ((hold_run  != '1) ? hold_run  + 1'b1 : hold_run)  : '0;
    end
  end

  p_idle_when_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_en |-> ce_n_out);

  p_fast_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && ce_n_in) |-> !pass_en);

  p_open_only_mid_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && pass_en) |-> !ce_n_in);

  p_drain_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && pass_en) |-> (drain_run <= 16'(DELAY_CYC)));

  p_stay_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && !pass_en) |=> !pass_en);

  p_closed_at_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> !pass_en);

  p_hold_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && !pass_en) |-> (hold_run <= 16'(HOLD_CYC)));
endmodule

bind ce_guard ce_guard_chk #(
  .DELAY_CYC (DELAY_CYC),
  .HOLD_CYC  (HOLD_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sys_rst  (sys_rst),
  .ce_n_in  (ce_n_in),
  .ce_n_out (ce_n_out),
  .pass_en  (pass_en)
);

// File: tb/sim_ce_guard.sv
`timescale 1ns/100ps
module sim_ce_guard;
  localparam int DLY  = 6;
  localparam int REL  = 20;
  localparam int HFULL = REL;
  localparam int HHALF = REL / 2;

  typedef struct {
    logic [1:0] out;
    logic [1:0] pe;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b1;
  logic ce_n = 1'b1;
  logic [1:0] out_w, pe_w;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sbq[$];

  // reference model state per instance: 0 open, 1 drain, 2 shut, 3 hold
  int md[2] = '{2, 2};
  int kk[2] = '{0, 0};
  int hl[2] = '{HFULL, HHALF};

  always #2.5 clk = ~clk;

  ce_guard #(.DELAY_CYC(DLY), .REL_CYC(REL), .HALF_HOLD(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .ce_n_in(ce_n),
    .ce_n_out(out_w[0]), .pass_en(pe_w[0]));

  ce_guard #(.DELAY_CYC(DLY), .REL_CYC(REL), .HALF_HOLD(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .ce_n_in(ce_n),
    .ce_n_out(out_w[1]), .pass_en(pe_w[1]));

  task automatic step(input logic pr, input logic r, input logic ce, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = pr; sys_rst = r; ce_n = ce;
    for (int i = 0; i < 2; i++) begin
      logic p;
      if (!pr)            p = 1'b0;
      else if (md[i] == 0) p = !(r && ce);
      else if (md[i] == 1) p = !ce;
      else                 p = 1'b0;
      e.pe[i]  = p;
      e.out[i] = p ? ce : 1'b1;
    end
    e.tag = tag;
    sbq.push_back(e);
    for (int i = 0; i < 2; i++) begin
      if (!pr) begin
        md[i] = 2; kk[i] = 0;
      end else begin
        case (md[i])
          0: if (r) begin md[i] = ce ? 2 : 1; kk[i] = 0; end
          1: if (ce || kk[i] == DLY - 1) md[i] = 2; else kk[i]++;
          2: if (!r) begin md[i] = 3; kk[i] = 0; end
          default: if (r) md[i] = 2;
                   else if (kk[i] == hl[i] - 1) md[i] = 0;
                   else kk[i]++;
        endcase
      end
    end
  endtask

  // monitor: pop one expected item per cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        for (int i = 0; i < 2; i++) begin
          n_cmp++;
          if (out_w[i] !== e.out[i] || pe_w[i] !== e.pe[i]) begin
            n_bad++;
            $display("FAIL %s%s u%0d: ce_n_out=%b pass_en=%b expected ce_n_out=%b pass_en=%b",
                     e.tag, (i == 1) ? "/R8" : "", i, out_w[i], pe_w[i], e.out[i], e.pe[i]);
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    // R7: power-on reset keeps the path closed
    for (int c = 0; c < 3; c++) step(1'b0, 1'b1, c[0], "R7");
    // R7 / R8: release with no system reset, hold before first open
    for (int c = 0; c < HFULL + 3; c++) step(1'b1, 1'b0, c[0], "R7");
    // R1: free toggling in normal running
    for (int c = 0; c < 10; c++) step(1'b1, 1'b0, (c % 3) == 0, "R1");
    // R3: reset with select high closes at once
    step(1'b1, 1'b1, 1'b1, "R3");
    // R2: select ignored while closed
    for (int c = 0; c < 5; c++) step(1'b1, 1'b1, c[0], "R2");
    // R6: release, hold with select toggling
    for (int c = 0; c < HFULL + 3; c++) step(1'b1, 1'b0, c[0], "R6");
    // R4: reset mid-access, select held low through the window
    step(1'b1, 1'b0, 1'b0, "R4");
    for (int c = 0; c < DLY + 4; c++) step(1'b1, 1'b1, 1'b0, "R4");
    for (int c = 0; c < HFULL + 2; c++) step(1'b1, 1'b0, 1'b0, "R6");
    // R5: select lifted inside the window, then low again
    step(1'b1, 1'b0, 1'b0, "R5");
    for (int c = 0; c < 2; c++) step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b1, "R5");
    for (int c = 0; c < 4; c++) step(1'b1, 1'b1, 1'b0, "R5");
    // R6: reset pulse inside the hold restarts it
    for (int c = 0; c < 5; c++) step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, "R6");
    for (int c = 0; c < HFULL + 3; c++) step(1'b1, 1'b0, c[1], "R6");
    // R1: normal running again
    for (int c = 0; c < 6; c++) step(1'b1, 1'b0, c[0], "R1");
    // R7: power-on reset from the open state
    step(1'b0, 1'b0, 1'b0, "R7");
    for (int c = 0; c < HFULL + 2; c++) step(1'b1, 1'b0, 1'b0, "R7");
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule